// File: doc/BRIEF.md
# Prioritised Interrupt Request Controller

This block gathers sixteen external interrupt request lines in front of a processor and presents at most one of them on a single interrupt output. Each line is set up by software to respond to a level, high or low, or to a rising or falling transition. Each line also gets a three-bit priority, and priority zero turns the line off. A global mask level hides every line whose priority is not strictly above it. A global enable bit gates the whole output.

Software reaches the controller through a plain 32-bit register port. Reads are combinational and writes take effect on the clock edge. A current-status word reports the number and priority of the winning line, with an active-low "presenting" flag. A raw status word shows which lines are asserted under their trigger setting, whatever their priority. Transition-triggered lines keep a sticky detection latch. Software clears that latch with a command write that names the line and carries a separate enable bit.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset every register reads 0, except the current-status word, which reads 0x0001_0000. `irq_out` is low.
- R2: Register map, by byte offset. 0x00 holds the enable in bit 0. 0x04 holds the trigger codes of lines 0–7 and 0x08 those of lines 8–15; line n uses bits (n mod 8)*2+1:(n mod 8)*2. The level words sit at 0x10 + 4*k for k = 0..7; line n is in word n/2, in the field starting at bit (n mod 2)*8. 0x40 holds the mask level in bits 2:0. The clear command is at 0x60, the raw status at 0x80 and the current status at 0xA0. Any other offset reads 0, as do unused bits.
- R3: Only the low 3 bits of each 8-bit level field are stored. A level word written with all ones reads back 0x0000_0707.
- R4: Trigger code 00 makes a line asserted while its input is low. Code 01 makes it asserted while its input is high.
- R5: Code 10 sets the line's latch on a falling transition and code 11 on a rising one. The line stays asserted after the input returns, until the latch is cleared.
- R6: A write to 0x60 with bit 8 set clears the latch of the line numbered in bits 3:0. With bit 8 clear the write changes nothing.
- R7: A line is a candidate only when it is asserted and its level is strictly greater than the mask level. A level of 0 never qualifies.
- R8: The candidate with the highest level wins. Equal levels go to the lowest line number.
- R9: Current status at 0xA0: bit 16 is 0 while a line is presented and 1 otherwise, bits 10:8 give the winner's level and bits 4:0 its number. When nothing is presented, bits 10:8 and 4:0 read 0. `irq_out` is high exactly when bit 16 is 0.
- R10: With enable bit 0 clear, `irq_out` stays low and bit 16 of the current status reads 1.
- R11: The raw status at 0x80 has bit n set while line n is asserted under its trigger code, regardless of level, mask and enable.
- R12: Inputs pass two synchronizing flops. A level-triggered change reaches `irq_out` after the second rising clock edge; a transition-triggered one after the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_in | input | 16 | External interrupt request lines |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when not reading |
| irq_out | output | 1 | Interrupt to the processor |

## Verification
A register write lands on the rising edge that samples it. Its effect on `irq_out` and on the status words shows up right after that edge. A change on a level-triggered input shows two edges after it is driven, and a transition-triggered one three edges after. The bench drives inputs on falling edges and waits four full clocks after every input change before sampling on a falling edge. One directed test watches the output one edge before and one edge at the due cycle, which pins both latencies exactly.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int LVL_W    = 3;
  localparam int CODE_W   = 2;
  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 32;
  localparam int FIELD_W  = 8;   // width of one level field in a level word
  localparam int SRC_PER_TRIG = 8;
  localparam int SRC_PER_LVL  = 2;

  localparam logic [ADDR_W-1:0] OFS_EN   = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_TRIG = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_LVL  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_MASK = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_CLR  = 8'h60;
  localparam logic [ADDR_W-1:0] OFS_RAW  = 8'h80;
  localparam logic [ADDR_W-1:0] OFS_CUR  = 8'hA0;

  localparam int CLR_GO_BIT = 8;
  localparam int CUR_NONE_BIT = 16;
  localparam int CUR_LVL_LSB  = 8;

  typedef logic [LVL_W-1:0]  lvl_t;
  typedef logic [CODE_W-1:0] code_t;

  // code bit 1 selects transition mode, bit 0 selects high/rising
  function automatic logic is_edge_code(input code_t c);
    return c[1];
  endfunction

  function automatic logic line_asserted(input code_t c, input logic lvl_in,
                                         input logic latched);
    if (c[1]) return latched;
    return c[0] ? lvl_in : ~lvl_in;
  endfunction

  function automatic logic edge_seen(input code_t c, input logic now_v,
                                     input logic prev_v);
    if (!c[1]) return 1'b0;
    return c[0] ? (now_v & ~prev_v) : (~now_v & prev_v);
  endfunction

  function automatic logic qualifies(input logic en, input logic asserted,
                                     input lvl_t lvl, input lvl_t mask);
    return en & asserted & (lvl > mask);
  endfunction
endpackage

// File: rtl/irq_src_detect.sv
module irq_src_detect
  import irq_prio_pkg::*;
#(
  parameter int NSRC = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NSRC-1:0]        req_in,
  input  logic [NSRC*CODE_W-1:0] codes,
  input  logic [NSRC-1:0]        clr_vec,
  output logic [NSRC-1:0]        asserted,
  output logic [NSRC-1:0]        edge_set,
  output logic [NSRC-1:0]        edge_latch
);
  logic [NSRC-1:0] sync1_q, sync2_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
    end else begin
      sync1_q <= req_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  for (genvar n = 0; n < NSRC; n++) begin : g_line
    code_t c;
    assign c           = codes[n*CODE_W +: CODE_W];
    assign edge_set[n] = edge_seen(c, sync2_q[n], prev_q[n]);

    // a fresh transition wins over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           edge_latch[n] <= 1'b0;
      else if (edge_set[n]) edge_latch[n] <= 1'b1;
      else if (clr_vec[n])  edge_latch[n] <= 1'b0;
    end

    assign asserted[n] = line_asserted(c, sync2_q[n], edge_latch[n]);
  end
endmodule

// File: rtl/irq_prio_select.sv
module irq_prio_select
  import irq_prio_pkg::*;
#(
  parameter int NSRC = 16,
  localparam int ID_W = $clog2(NSRC)
) (
  input  logic                  en,
  input  logic [NSRC-1:0]       asserted,
  input  logic [NSRC*LVL_W-1:0] levels,
  input  lvl_t                  mask,
  output logic                  sel_valid,
  output logic [ID_W-1:0]       sel_id,
  output lvl_t                  sel_lvl
);
  logic [NSRC-1:0] cand;

  for (genvar n = 0; n < NSRC; n++) begin : g_cand
    assign cand[n] = qualifies(en, asserted[n], levels[n*LVL_W +: LVL_W], mask);
  end

  // strict compare while scanning upward keeps the lowest number on ties
  always_comb begin
    sel_valid = 1'b0;
    sel_id    = '0;
    sel_lvl   = '0;
    for (int n = 0; n < NSRC; n++) begin
      if (cand[n] && (levels[n*LVL_W +: LVL_W] > sel_lvl)) begin
        sel_valid = 1'b1;
        sel_id    = ID_W'(n);
        sel_lvl   = levels[n*LVL_W +: LVL_W];
      end
    end
  end
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_prio_pkg::*;
#(
  parameter int NSRC = 16,
  localparam int ID_W   = $clog2(NSRC),
  localparam int N_TRIG = NSRC / SRC_PER_TRIG,
  localparam int N_LVL  = NSRC / SRC_PER_LVL,
  localparam int TRIG_BITS = SRC_PER_TRIG * CODE_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_en,
  input  logic                   bus_we,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [DATA_W-1:0]      bus_wdata,
  output logic [DATA_W-1:0]      bus_rdata,
  input  logic [NSRC-1:0]        asserted,
  input  logic                   sel_valid,
  input  logic [ID_W-1:0]        sel_id,
  input  lvl_t                   sel_lvl,
  output logic                   en_bit,
  output logic [NSRC*CODE_W-1:0] codes,
  output logic [NSRC*LVL_W-1:0]  levels,
  output lvl_t                   mask_lvl,
  output logic [NSRC-1:0]        clr_vec,
  output logic [DATA_W-1:0]      cur_word
);
  logic wr_go, rd_go;
  assign wr_go = bus_en & bus_we;
  assign rd_go = bus_en & ~bus_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_bit   <= 1'b0;
      codes    <= '0;
      levels   <= '0;
      mask_lvl <= '0;
    end else if (wr_go) begin
      if (bus_addr == OFS_EN)   en_bit   <= bus_wdata[0];
      if (bus_addr == OFS_MASK) mask_lvl <= bus_wdata[LVL_W-1:0];
      for (int k = 0; k < N_TRIG; k++)
        if (bus_addr == OFS_TRIG + ADDR_W'(4*k))
          codes[k*TRIG_BITS +: TRIG_BITS] <= bus_wdata[TRIG_BITS-1:0];
      for (int k = 0; k < N_LVL; k++)
        if (bus_addr == OFS_LVL + ADDR_W'(4*k)) begin
          levels[(2*k)*LVL_W +: LVL_W]   <= bus_wdata[LVL_W-1:0];
          levels[(2*k+1)*LVL_W +: LVL_W] <= bus_wdata[FIELD_W +: LVL_W];
        end
    end
  end

  // clear command: go bit plus line number
  always_comb begin
    clr_vec = '0;
    if (wr_go && bus_addr == OFS_CLR && bus_wdata[CLR_GO_BIT])
      clr_vec[bus_wdata[ID_W-1:0]] = 1'b1;
  end

  always_comb begin
    cur_word = '0;
    cur_word[CUR_NONE_BIT] = ~sel_valid;
    cur_word[CUR_LVL_LSB +: LVL_W] = sel_lvl;
    cur_word[ID_W-1:0] = sel_id;
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_go) begin
      if (bus_addr == OFS_EN)   bus_rdata[0] = en_bit;
      if (bus_addr == OFS_MASK) bus_rdata[LVL_W-1:0] = mask_lvl;
      if (bus_addr == OFS_RAW)  bus_rdata[NSRC-1:0] = asserted;
      if (bus_addr == OFS_CUR)  bus_rdata = cur_word;
      for (int k = 0; k < N_TRIG; k++)
        if (bus_addr == OFS_TRIG + ADDR_W'(4*k))
          bus_rdata[TRIG_BITS-1:0] = codes[k*TRIG_BITS +: TRIG_BITS];
      for (int k = 0; k < N_LVL; k++)
        if (bus_addr == OFS_LVL + ADDR_W'(4*k)) begin
          bus_rdata[LVL_W-1:0]       = levels[(2*k)*LVL_W +: LVL_W];
          bus_rdata[FIELD_W +: LVL_W] = levels[(2*k+1)*LVL_W +: LVL_W];
        end
    end
  end

  logic unused_wdata;
  assign unused_wdata = &{1'b0, bus_wdata};
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int NSRC = 16,
  localparam int ID_W = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   req_in,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_out
);
  logic                   en_bit;
  logic [NSRC*CODE_W-1:0] codes;
  logic [NSRC*LVL_W-1:0]  levels;
  lvl_t                   mask_lvl;
  logic [NSRC-1:0]        clr_vec;
  logic [NSRC-1:0]        asserted, edge_set, edge_latch;
  logic                   sel_valid;
  logic [ID_W-1:0]        sel_id;
  lvl_t                   sel_lvl;
  logic [DATA_W-1:0]      cur_word;

  irq_regfile #(.NSRC(NSRC)) regs_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .asserted(asserted), .sel_valid(sel_valid), .sel_id(sel_id),
    .sel_lvl(sel_lvl), .en_bit(en_bit), .codes(codes), .levels(levels),
    .mask_lvl(mask_lvl), .clr_vec(clr_vec), .cur_word(cur_word)
  );

  irq_src_detect #(.NSRC(NSRC)) det_i (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .codes(codes),
    .clr_vec(clr_vec), .asserted(asserted), .edge_set(edge_set),
    .edge_latch(edge_latch)
  );

  irq_prio_select #(.NSRC(NSRC)) sel_i (
    .en(en_bit), .asserted(asserted), .levels(levels), .mask(mask_lvl),
    .sel_valid(sel_valid), .sel_id(sel_id), .sel_lvl(sel_lvl)
  );

  assign irq_out = sel_valid;
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
  import irq_prio_pkg::*;
#(
  parameter int NSRC = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_out,
  input logic              en_bit,
  input lvl_t              mask_lvl,
  input lvl_t              sel_lvl,
  input logic [NSRC-1:0]   edge_set,
  input logic [NSRC-1:0]   edge_latch,
  input logic [NSRC-1:0]   clr_vec,
  input logic [DATA_W-1:0] cur_word
);
  p_disabled_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en_bit |-> !irq_out);

  p_above_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (sel_lvl > mask_lvl));

  p_flag_matches_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == !cur_word[CUR_NONE_BIT]);

  p_edge_sets_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_set != '0) |=> ((edge_latch & $past(edge_set)) == $past(edge_set)));

  p_latch_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_latch != '0) |=>
      ((edge_latch & $past(edge_latch & ~clr_vec)) == $past(edge_latch & ~clr_vec)));

  p_clear_works_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec != '0) && ((clr_vec & edge_set) == '0)) |=>
      ((edge_latch & $past(clr_vec)) == '0));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.NSRC(NSRC)) chk_i (
  .clk(clk), .rst_n(rst_n), .irq_out(irq_out), .en_bit(en_bit),
  .mask_lvl(mask_lvl), .sel_lvl(sel_lvl), .edge_set(edge_set),
  .edge_latch(edge_latch), .clr_vec(clr_vec), .cur_word(cur_word)
);

// File: tb/irq_prio_ctrl_tb_top.sv
module irq_prio_ctrl_tb_top;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] req_in = '0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;

  always #2 clk = ~clk;

  irq_prio_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .bus_en(bus_en),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // bench-side view of the programmed state
  logic [1:0] m_code [N];
  logic [2:0] m_lvl  [N];
  logic [2:0] m_mask;
  logic       m_en;
  logic [N-1:0] m_lat;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_en = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_en = 0;
  endtask

  function automatic logic m_asserted(input int n);
    if (m_code[n][1]) return m_lat[n];
    return m_code[n][0] ? req_in[n] : ~req_in[n];
  endfunction

  function automatic logic [N-1:0] m_raw();
    logic [N-1:0] r;
    for (int n = 0; n < N; n++) r[n] = m_asserted(n);
    return r;
  endfunction

  function automatic logic [31:0] m_cur();
    logic v; logic [2:0] bl; logic [3:0] bi;
    v = 0; bl = 0; bi = 0;
    for (int n = 0; n < N; n++)
      if (m_en && m_asserted(n) && m_lvl[n] > m_mask && m_lvl[n] > bl) begin
        v = 1; bl = m_lvl[n]; bi = 4'(n);
      end
    return {15'b0, ~v, 5'b0, bl, 4'b0, bi};
  endfunction

  // model-side writes
  task automatic set_trig(input int k, input logic [31:0] d);
    wr(8'h04 + 8'(4*k), d);
    for (int j = 0; j < 8; j++) m_code[k*8+j] = d[2*j +: 2];
  endtask

  task automatic set_lvl(input int k, input logic [31:0] d);
    wr(8'h10 + 8'(4*k), d);
    m_lvl[2*k] = d[2:0];
    m_lvl[2*k+1] = d[10:8];
  endtask

  task automatic set_mask(input logic [31:0] d);
    wr(8'h40, d); m_mask = d[2:0];
  endtask

  task automatic set_en(input logic [31:0] d);
    wr(8'h00, d); m_en = d[0];
  endtask

  task automatic clr_cmd(input logic [31:0] d);
    wr(8'h60, d);
    if (d[8]) m_lat[d[3:0]] = 1'b0;
  endtask

  task automatic drive(input logic [N-1:0] v);
    @(negedge clk);
    for (int n = 0; n < N; n++)
      if (m_code[n][1] && (m_code[n][0] ? (!req_in[n] && v[n]) : (req_in[n] && !v[n])))
        m_lat[n] = 1'b1;
    req_in = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    logic [31:0] d;
    logic [31:0] ec;
    ec = m_cur();
    #1;
    check({tag, " irq_out"}, {31'b0, irq_out}, {31'b0, ~ec[16]});
    rd(8'hA0, d); check({tag, " current status"}, d, ec);
    rd(8'h80, d); check({tag, " raw status"}, d, {16'b0, m_raw()});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h1CE5));
    for (int n = 0; n < N; n++) begin m_code[n] = 0; m_lvl[n] = 0; end
    m_mask = 0; m_en = 0; m_lat = '0;

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq_out", {31'b0, irq_out}, 32'h0);
    rd(8'hA0, d); check("R1 current status", d, 32'h0001_0000);
    rd(8'h00, d); check("R1 enable", d, 32'h0);
    rd(8'h04, d); check("R1 trigger 0", d, 32'h0);
    rd(8'h2C, d); check("R1 level 7", d, 32'h0);
    rd(8'h40, d); check("R1 mask", d, 32'h0);

    // R2 / R3 readback and unused offsets
    set_trig(1, 32'hFFFF_FFFF);
    rd(8'h08, d); check("R2 trigger 1 readback", d, 32'h0000_FFFF);
    rd(8'h04, d); check("R2 trigger 0 untouched", d, 32'h0);
    set_lvl(3, 32'hFFFF_FFFF);
    rd(8'h1C, d); check("R3 level 3 upper bits zero", d, 32'h0000_0707);
    set_mask(32'hFFFF_FFFF);
    rd(8'h40, d); check("R2 mask readback", d, 32'h7);
    rd(8'h0C, d); check("R2 unused offset 0x0C", d, 32'h0);
    rd(8'h30, d); check("R2 unused offset 0x30", d, 32'h0);
    set_trig(1, 0); set_lvl(3, 0); set_mask(0);

    // R4 / R12 level latency on line 3, active high
    set_en(1);
    set_trig(0, 32'h0000_0040);          // line 3 code 01
    set_lvl(1, 32'h0000_0500);           // line 3 level 5
    @(negedge clk); req_in[3] = 1'b1;
    @(negedge clk); check("R12 level not yet after 1 edge", {31'b0, irq_out}, 0);
    @(negedge clk); check("R12 level due after 2 edges", {31'b0, irq_out}, 1);
    repeat (3) @(negedge clk);
    check_all("R4 active high");
    drive(req_in & ~16'h0008);
    check_all("R4 released");

    // R5 / R12 rising edge on line 7
    set_trig(0, 32'h0000_C040);          // line 7 code 11
    set_lvl(3, 32'h0000_0200);           // line 7 level 2
    @(negedge clk); req_in[7] = 1'b1;
    @(negedge clk);
    @(negedge clk); check("R12 edge not yet after 2 edges", {31'b0, irq_out}, 0);
    @(negedge clk); check("R12 edge due after 3 edges", {31'b0, irq_out}, 1);
    m_lat[7] = 1'b1;
    drive(req_in & ~16'h0080);
    check_all("R5 latch holds after release");

    // R6 clear command without go bit, then with it
    clr_cmd(32'h0000_0007);
    check_all("R6 no go bit no effect");
    clr_cmd(32'h0000_0107);
    check_all("R6 go bit clears");

    // R8 tie on equal levels, R7 mask
    set_trig(1, 32'h0000_0014);          // lines 9,10 active high
    set_lvl(4, 32'h0600_0000);
    set_lvl(4, 32'h0000_0600);           // line 9 level 6
    set_lvl(5, 32'h0000_0006);           // line 10 level 6
    drive(16'h0600);
    check_all("R8 tie lowest number");
    set_mask(6);
    check_all("R7 mask equal blocks");
    set_en(0); set_mask(0);
    check_all("R10 enable off");
    set_en(1);

    // random phase
    for (int it = 0; it < 400; it++) begin
      case ($urandom_range(0, 5))
        0: drive(16'($urandom));
        1: set_trig($urandom_range(0, 1), $urandom);
        2: set_lvl($urandom_range(0, 7), $urandom);
        3: set_mask($urandom);
        4: clr_cmd($urandom & 32'h0000_010F);
        default: set_en(($urandom_range(0, 3) != 0) ? 1 : 0);
      endcase
      check_all("R11 R8 R7 R9 random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule